// File: doc/BRIEF.md
# Descending Word Stack Controller

This block keeps a last-in-first-out stack of 32-bit words in an ordinary byte-addressed memory that sits outside it. A pointer register always names the byte address of the word currently on top. The stack fills toward lower addresses. A push moves the pointer down by one word (four bytes) and then writes the word at the new pointer. A pop reads the word at the pointer and then moves the pointer up by four.

Two parameters bound the region the stack may use. `BOTTOM` is the address that holds the first element pushed. `LIMIT` is the lowest address an element may occupy. A push that would go below `LIMIT` is refused with a one-cycle overflow pulse. A pop on an empty stack is refused with a one-cycle underflow pulse.

The memory port expects a synchronous memory with one cycle of read latency. A push is accepted and finished in a single cycle. A pop keeps `busy` high for two cycles while it waits for the read and then updates the pointer.

Top module: `lifo_stack`

## Requirements
- R1: After synchronous reset, `stack_ptr` equals BOTTOM+4, `empty` is 1, and `busy`, `pop_valid`, `mem_we`, `overflow` and `underflow` are all 0.
- R2: A push accepted at a clock edge lowers `stack_ptr` by 4 at that edge. In the following cycle `mem_we` is 1 for one cycle, with `mem_addr` equal to the new pointer and `mem_wdata` equal to the pushed word.
- R3: A pop accepted at edge E0 drives `mem_addr` with the current pointer and `mem_we` low. At edge E0+2, `pop_valid` rises for exactly one cycle with the read word on `pop_data`, and `stack_ptr` rises by 4 at that same edge.
- R4: Words come back from pops in the reverse order of their pushes.
- R5: After a pop is accepted, `busy` is 1 for exactly two cycles. Push or pop requests seen while `busy` is 1 have no effect.
- R6: A pop while empty is refused. `underflow` is 1 for the one cycle after the request, `stack_ptr` is unchanged and `pop_valid` stays 0.
- R7: A push when `stack_ptr` is less than LIMIT+4 is refused. `overflow` is 1 for the one cycle after the request, there is no memory write, and `stack_ptr` is unchanged.
- R8: When push and pop are both requested in an idle cycle, only the push is considered. The pop is dropped even if the push is refused.
- R9: `empty` is 1 exactly when `stack_ptr` equals BOTTOM+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Push request strobe |
| pop_req | input | 1 | Pop request strobe |
| push_data | input | 32 | Word to push |
| pop_data | output | 32 | Word returned by a pop |
| pop_valid | output | 1 | One-cycle pulse marking pop_data valid |
| busy | output | 1 | Pop in progress; requests ignored |
| empty | output | 1 | Stack holds no element |
| overflow | output | 1 | One-cycle pulse: push refused |
| underflow | output | 1 | One-cycle pulse: pop refused |
| stack_ptr | output | ADDR_W | Byte address of the top element |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the address |

## Verification
The hardest state to reach from the ports is a full stack with both strobes raised together. Here the push is refused for lack of room, and the pop that came with it must still be dropped rather than served. The stimulus table fills the stack to exactly `LIMIT` before it fires that combined request, and then pops to confirm that the pointer and the contents are unchanged. A second directed test holds both strobes high through an entire pop. This shows that nothing is accepted during the two busy cycles.

// File: rtl/lifo_pkg.sv
package lifo_pkg;
  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_WAIT = 2'd1,
    ST_RD_DONE = 2'd2
  } lifo_state_e;
endpackage

// File: rtl/lifo_sp_reg.sv
module lifo_sp_reg
  import lifo_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BOTTOM = 32'h0000_0100,
  parameter int unsigned LIMIT  = 32'h0000_00F0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] sp_dn_o,
  output logic              empty_o,
  output logic              room_o
);
  localparam logic [ADDR_W-1:0] SP_EMPTY    = ADDR_W'(BOTTOM + WORD_BYTES);
  localparam logic [ADDR_W:0]   SP_MIN_PUSH = (ADDR_W+1)'(LIMIT + WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP        = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= SP_EMPTY;
    end else if (dec_i) begin
      sp_q <= sp_q - STEP;
    end else if (inc_i) begin
      sp_q <= sp_q + STEP;
    end
  end

  assign sp_o    = sp_q;
  assign sp_dn_o = sp_q - STEP;
  assign empty_o = (sp_q == SP_EMPTY);
  assign room_o  = ({1'b0, sp_q} >= SP_MIN_PUSH);
endmodule

// File: rtl/lifo_seq.sv
module lifo_seq
  import lifo_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [ADDR_W-1:0] sp,
  input  logic [ADDR_W-1:0] sp_dn,
  input  logic              empty,
  input  logic              room,
  output logic              sp_dec,
  output logic              sp_inc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_valid,
  output logic              busy,
  output logic              overflow,
  output logic              underflow
);
  lifo_state_e state_q, state_d;
  logic idle, push_go, pop_go, push_bad, pop_bad;

  always_comb begin
    idle     = (state_q == ST_IDLE);
    push_go  = idle && push_req && room;
    push_bad = idle && push_req && !room;
    pop_go   = idle && !push_req && pop_req && !empty;
    pop_bad  = idle && !push_req && pop_req && empty;
    sp_dec   = push_go;
    sp_inc   = (state_q == ST_RD_DONE);
    unique case (state_q)
      ST_IDLE:    state_d = pop_go ? ST_RD_WAIT : ST_IDLE;
      ST_RD_WAIT: state_d = ST_RD_DONE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      pop_data  <= '0;
      pop_valid <= 1'b0;
      busy      <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      state_q   <= state_d;
      busy      <= (state_d != ST_IDLE);
      mem_we    <= push_go;
      overflow  <= push_bad;
      underflow <= pop_bad;
      pop_valid <= (state_q == ST_RD_DONE);
      if (push_go) begin
        mem_addr  <= sp_dn;
        mem_wdata <= push_data;
      end else if (pop_go) begin
        mem_addr <= sp;
      end
      if (state_q == ST_RD_DONE) begin
        pop_data <= mem_rdata;
      end
    end
  end
endmodule

// File: rtl/lifo_stack.sv
module lifo_stack #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BOTTOM = 32'h0000_0100,
  parameter int unsigned LIMIT  = 32'h0000_00F0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [DATA_W-1:0] push_data,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_valid,
  output logic              busy,
  output logic              empty,
  output logic              overflow,
  output logic              underflow,
  output logic [ADDR_W-1:0] stack_ptr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic              sp_dec, sp_inc, room;
  logic [ADDR_W-1:0] sp_dn;

  lifo_sp_reg #(
    .ADDR_W(ADDR_W), .BOTTOM(BOTTOM), .LIMIT(LIMIT)
  ) u_sp (
    .clk(clk), .rst(rst), .dec_i(sp_dec), .inc_i(sp_inc),
    .sp_o(stack_ptr), .sp_dn_o(sp_dn), .empty_o(empty), .room_o(room)
  );

  lifo_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .push_data(push_data), .mem_rdata(mem_rdata), .sp(stack_ptr),
    .sp_dn(sp_dn), .empty(empty), .room(room), .sp_dec(sp_dec),
    .sp_inc(sp_inc), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .pop_data(pop_data), .pop_valid(pop_valid),
    .busy(busy), .overflow(overflow), .underflow(underflow)
  );
endmodule

// File: rtl/lifo_stack_chk.sv
module lifo_stack_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BOTTOM = 32'h0000_0100,
  parameter int unsigned LIMIT  = 32'h0000_00F0
) (
  input logic              clk,
  input logic              rst,
  input logic              push_req,
  input logic              pop_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] stack_ptr,
  input logic              pop_valid,
  input logic              busy,
  input logic              empty,
  input logic              overflow,
  input logic              underflow
);
  localparam logic [ADDR_W-1:0] SP_EMPTY = ADDR_W'(BOTTOM + 4);
  localparam logic [ADDR_W:0]   SP_LOW   = (ADDR_W+1)'(LIMIT);

  AST_WRITE_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == stack_ptr)); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    pop_valid |=> !pop_valid); // R3
  AST_POP_STARTS: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push_req && !busy && !empty) |=> busy); // R3
  AST_BUSY_TWO: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy); // R5
  AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |=> !busy); // R5
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    pop_valid |-> !busy); // R5
  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    underflow |-> (empty && !busy && !pop_valid)); // R6
  AST_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (!mem_we && $stable(stack_ptr))); // R7
  AST_SP_RANGE: assert property (@(posedge clk) disable iff (rst)
    (({1'b0, stack_ptr} >= SP_LOW) && (stack_ptr <= SP_EMPTY))); // R7
  AST_PUSH_PRIO: assert property (@(posedge clk) disable iff (rst)
    (push_req && pop_req && !busy) |=> !busy); // R8
endmodule

bind lifo_stack lifo_stack_chk #(
  .ADDR_W(ADDR_W), .BOTTOM(BOTTOM), .LIMIT(LIMIT)
) u_chk (
  .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .stack_ptr(stack_ptr),
  .pop_valid(pop_valid), .busy(busy), .empty(empty),
  .overflow(overflow), .underflow(underflow)
);

// File: tb/lifo_stack_tb.sv
module lifo_stack_tb;
  localparam int ADDR_W = 16;
  localparam logic [15:0] SP_EMPTY = 16'h0104;
  localparam logic [1:0] OP_PUSH = 2'd0, OP_POP = 2'd1, OP_BOTH = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] din;
    logic [15:0] sp;
    logic [31:0] dout;
    logic [1:0]  flg;   // [0] overflow expected, [1] underflow expected
  } row_t;

  localparam row_t TBL [18] = '{
    '{OP_POP,  32'h0,         16'h0104, 32'h0,         2'b10},
    '{OP_PUSH, 32'hA1A1_0001, 16'h0100, 32'h0,         2'b00},
    '{OP_PUSH, 32'hA2A2_0002, 16'h00FC, 32'h0,         2'b00},
    '{OP_POP,  32'h0,         16'h0100, 32'hA2A2_0002, 2'b00},
    '{OP_PUSH, 32'hA3A3_0003, 16'h00FC, 32'h0,         2'b00},
    '{OP_PUSH, 32'hA4A4_0004, 16'h00F8, 32'h0,         2'b00},
    '{OP_PUSH, 32'hA5A5_0005, 16'h00F4, 32'h0,         2'b00},
    '{OP_PUSH, 32'hA6A6_0006, 16'h00F0, 32'h0,         2'b00},
    '{OP_PUSH, 32'hA7A7_0007, 16'h00F0, 32'h0,         2'b01},
    '{OP_BOTH, 32'hA8A8_0008, 16'h00F0, 32'h0,         2'b01},
    '{OP_POP,  32'h0,         16'h00F4, 32'hA6A6_0006, 2'b00},
    '{OP_BOTH, 32'hA9A9_0009, 16'h00F0, 32'h0,         2'b00},
    '{OP_POP,  32'h0,         16'h00F4, 32'hA9A9_0009, 2'b00},
    '{OP_POP,  32'h0,         16'h00F8, 32'hA5A5_0005, 2'b00},
    '{OP_POP,  32'h0,         16'h00FC, 32'hA4A4_0004, 2'b00},
    '{OP_POP,  32'h0,         16'h0100, 32'hA3A3_0003, 2'b00},
    '{OP_POP,  32'h0,         16'h0104, 32'hA1A1_0001, 2'b00},
    '{OP_POP,  32'h0,         16'h0104, 32'h0,         2'b10}
  };

  logic clk = 1'b0, rst = 1'b1, push_req = 1'b0, pop_req = 1'b0;
  logic [31:0] push_data = '0, pop_data, mem_wdata, mem_rdata;
  logic pop_valid, busy, empty, overflow, underflow, mem_we;
  logic [ADDR_W-1:0] stack_ptr, mem_addr;
  logic [31:0] mem [256];
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:2]];
  end

  lifo_stack #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .push_data(push_data), .pop_data(pop_data), .pop_valid(pop_valid),
    .busy(busy), .empty(empty), .overflow(overflow), .underflow(underflow),
    .stack_ptr(stack_ptr), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_row(row_t r, int idx);
    string tag;
    logic push_ok;
    tag = r.flg[0] ? "R7" : r.flg[1] ? "R6" : (r.op == OP_BOTH) ? "R8" :
          (r.op == OP_POP) ? "R4" : "R2";
    tag = $sformatf("%s row %0d", tag, idx);
    push_ok = (r.op != OP_POP) && !r.flg[0];
    @(negedge clk);
    push_req  = (r.op != OP_POP);
    pop_req   = (r.op != OP_PUSH);
    push_data = r.din;
    @(posedge clk);
    @(negedge clk);
    push_req = 1'b0;
    pop_req  = 1'b0;
    check({tag, " overflow"}, 32'(overflow), 32'(r.flg[0]));
    check({tag, " underflow"}, 32'(underflow), 32'(r.flg[1]));
    check({tag, " mem_we"}, 32'(mem_we), 32'(push_ok));
    if (push_ok) begin
      check({tag, " R2 write addr"}, 32'(mem_addr), 32'(r.sp));
      check({tag, " R2 write data"}, mem_wdata, r.din);
    end
    if (r.op == OP_POP && !r.flg[1]) begin
      check({tag, " R5 busy"}, 32'(busy), 32'd1);
      @(negedge clk);
      @(negedge clk);
      check({tag, " R3 pop_valid"}, 32'(pop_valid), 32'd1);
      check({tag, " R4 pop_data"}, pop_data, r.dout);
    end else begin
      @(negedge clk);
      @(negedge clk);
      check({tag, " R3 no pop_valid"}, 32'(pop_valid), 32'd0);
    end
    check({tag, " stack_ptr"}, 32'(stack_ptr), 32'(r.sp));
    check({tag, " R9 empty"}, 32'(empty), 32'(r.sp == SP_EMPTY));
  endtask

  initial begin : watchdog
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 stack_ptr", 32'(stack_ptr), 32'(SP_EMPTY));
    check("R1 empty", 32'(empty), 32'd1);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 pop_valid", 32'(pop_valid), 32'd0);
    check("R1 mem_we", 32'(mem_we), 32'd0);
    check("R1 flags", 32'({overflow, underflow}), 32'd0);

    for (int i = 0; i < 18; i++) run_row(TBL[i], i);

    // R5: requests held during a pop are ignored; busy lasts two cycles
    @(negedge clk);
    push_req = 1'b1; push_data = 32'hB1B1_0011;
    @(posedge clk);
    @(negedge clk);
    push_req = 1'b0; pop_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R5 busy first", 32'(busy), 32'd1);
    push_req = 1'b1; push_data = 32'hDEAD_0000;
    @(posedge clk);
    @(negedge clk);
    check("R5 busy second", 32'(busy), 32'd1);
    check("R5 push ignored", 32'(mem_we), 32'd0);
    @(posedge clk);
    @(negedge clk);
    push_req = 1'b0; pop_req = 1'b0;
    check("R5 busy released", 32'(busy), 32'd0);
    check("R5 pop_valid", 32'(pop_valid), 32'd1);
    check("R5 pop_data", pop_data, 32'hB1B1_0011);
    check("R5 stack_ptr", 32'(stack_ptr), 32'(SP_EMPTY));
    @(negedge clk);
    check("R5 no late write", 32'(mem_we), 32'd0);
    check("R5 stack_ptr held", 32'(stack_ptr), 32'(SP_EMPTY));

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule